// File: doc/BRIEF.md
# Relocatable Protected Scratchpad Memory

This block provides fast local data storage made of four separate 1 KB banks, 4096 bytes in all. Each bank has its own base address, which is set through a configuration port and aligned to 1 KB, so software can place any bank anywhere in a 32-bit address space. Each bank also carries two protection attributes. One restricts the bank to supervisor-mode accesses. The other makes the bank read-only.

Accesses arrive on a simple single-cycle request bus. Every request is compared against all enabled banks at once. If the lowest-numbered matching bank permits the access, the block acknowledges it one cycle later and returns read data in that same cycle. If the bank forbids the access, the block raises an error response for one cycle instead, and neither memory nor the read data is affected. A request that falls in no bank gets no response at all, so another responder on the same bus can claim it.

Top module: `scratch_mem`

## Requirements
- R1: After reset every bank is disabled, and `rsp_ack`, `rsp_err` and `rsp_rdata` are all zero.
- R2: A bank matches a request when its enable bit is set and `req_addr[31:10]` equals its base. A permitted access to a matching bank raises `rsp_ack` for exactly one cycle, in the cycle after the request, with `rsp_err` low.
- R3: A permitted read returns the addressed 32-bit word on `rsp_rdata` in the same cycle as `rsp_ack`. The word is selected by `req_addr[9:2]` within the bank, and byte lane i occupies bits [8i+7:8i].
- R4: On a permitted write, `req_be[i]` enables byte lane i (`req_wdata[8i+7:8i]`). Lanes whose enable is clear keep their old contents, so 8-, 16- and 32-bit writes are all supported.
- R5: A bank whose supervisor-only attribute is set refuses every request with `req_super` = 0. A refused access raises `rsp_err` for one cycle in the cycle after the request, keeps `rsp_ack` low, and drives `rsp_rdata` to zero.
- R6: A bank whose read-only attribute is set refuses writes with an error response, and memory is unchanged. Reads from that bank are still permitted, subject to R5.
- R7: When several enabled banks match one address, only the lowest-numbered bank is used. Its protection attributes alone decide whether the access is refused.
- R8: A request that matches no enabled bank produces neither `rsp_ack` nor `rsp_err`, and a write of this kind changes no bank.
- R9: Writing a new base moves a bank. Its old address range stops responding, and its contents appear at the new range at the same offsets.
- R10: A bank with its enable bit clear never matches, whatever its base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the bank configuration registers |
| cfg_sel | input | 2 | Bank selected by a configuration write |
| cfg_base | input | 22 | New base, address bits [31:10] |
| cfg_en | input | 1 | New enable bit |
| cfg_sup_only | input | 1 | New supervisor-only attribute |
| cfg_rdonly | input | 1 | New read-only attribute |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_super | input | 1 | 1 for supervisor mode, 0 for user mode |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Byte lane enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | Access performed (one cycle after the request) |
| rsp_err | output | 1 | Access refused (one cycle after the request) |
| rsp_rdata | output | 32 | Read data, valid when `rsp_ack` follows a read; zero otherwise |

## Verification
The bench fills and reads back every word of all four banks at scattered, non-adjacent bases. This separates correct address decoding and offset mapping from aliasing between banks. Sixteen byte-enable values are applied to one word, so that each lane's write gating is told apart from its neighbours. The full matrix of the two attributes against privilege and direction is swept, with a supervisor read-back after each access to show that refused writes leave memory alone. Overlapping, relocated, disabled and unmapped address cases then tell the lowest-bank priority apart from the enable gate and from the bank's pass-through silence.

// File: rtl/scratch_mem.sv
module scratch_mem #(
  parameter int NBANK      = 4,
  parameter int BANK_BYTES = 1024,
  parameter int AW         = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_we,
  input  logic [(NBANK > 1 ? $clog2(NBANK) : 1)-1:0] cfg_sel,
  input  logic [AW-$clog2(BANK_BYTES)-1:0]       cfg_base,
  input  logic                                   cfg_en,
  input  logic                                   cfg_sup_only,
  input  logic                                   cfg_rdonly,
  input  logic                                   req_valid,
  input  logic                                   req_write,
  input  logic                                   req_super,
  input  logic [AW-1:0]                          req_addr,
  input  logic [3:0]                             req_be,
  input  logic [31:0]                            req_wdata,
  output logic                                   rsp_ack,
  output logic                                   rsp_err,
  output logic [31:0]                            rsp_rdata
);
  localparam int OFFW  = $clog2(BANK_BYTES);
  localparam int WORDS = BANK_BYTES / 4;
  localparam int BW    = AW - OFFW;

  logic [BW-1:0]    base_q [NBANK];
  logic [NBANK-1:0] en_q, sup_q, ro_q;
  logic [NBANK-1:0] hit, grant, blocked, wr_bank, rd_sel_q;
  logic [31:0]      rd_all [NBANK];
  logic [OFFW-3:0]  widx;
  logic             any_hit, go, deny;

  assign widx    = req_addr[OFFW-1:2];
  assign grant   = hit & (~hit + 1'b1);
  assign blocked = (sup_q & {NBANK{~req_super}}) | (ro_q & {NBANK{req_write}});
  assign any_hit = |hit;
  assign go      = req_valid && any_hit && !(|(grant & blocked));
  assign deny    = req_valid && any_hit && (|(grant & blocked));
  assign wr_bank = grant & {NBANK{go && req_write}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) base_q[b] <= '0;
      en_q  <= '0;
      sup_q <= '0;
      ro_q  <= '0;
    end else if (cfg_we) begin
      base_q[cfg_sel] <= cfg_base;
      en_q[cfg_sel]   <= cfg_en;
      sup_q[cfg_sel]  <= cfg_sup_only;
      ro_q[cfg_sel]   <= cfg_rdonly;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [31:0] mem [WORDS];
    logic [31:0] rd_q;

    assign hit[b]    = en_q[b] && (req_addr[AW-1:OFFW] == base_q[b]);
    assign rd_all[b] = rd_q;

    always_ff @(posedge clk) begin
      if (wr_bank[b])
        for (int i = 0; i < 4; i++)
          if (req_be[i]) mem[widx][8*i +: 8] <= req_wdata[8*i +: 8];
      rd_q <= mem[widx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ack  <= 1'b0;
      rsp_err  <= 1'b0;
      rd_sel_q <= '0;
    end else begin
      rsp_ack  <= go;
      rsp_err  <= deny;
      rd_sel_q <= grant & {NBANK{go && !req_write}};
    end
  end

  always_comb begin
    rsp_rdata = '0;
    for (int b = 0; b < NBANK; b++)
      if (rd_sel_q[b]) rsp_rdata = rsp_rdata | rd_all[b];
  end

  p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> $past(req_valid));

  p_ack_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ack && rsp_err));

  p_err_zero_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 32'h0));

  p_user_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_super && |(grant & sup_q)) |=> (rsp_err && !rsp_ack));

  p_ro_write_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && |(grant & ro_q)) |=> (rsp_err && !rsp_ack));

  p_nomatch_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && any_hit)) |=> (!rsp_ack && !rsp_err));
endmodule

// File: tb/tb_scratch_mem.sv
module tb_scratch_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [21:0] cfg_base = '0;
  logic        cfg_en = 1'b0, cfg_sup_only = 1'b0, cfg_rdonly = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ack, rsp_err;
  logic [31:0] rsp_rdata;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [31:0] model [4][256];
  logic [21:0] bb [4];

  always #2 clk = ~clk;

  scratch_mem dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int b, input logic [21:0] base, input bit en, input bit sup, input bit ro);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(b); cfg_base = base; cfg_en = en; cfg_sup_only = sup; cfg_rdonly = ro;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic acc(input bit wr, input bit sup, input logic [31:0] a, input logic [3:0] be,
                     input logic [31:0] wd, output bit ack, output bit err, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_super = sup; req_addr = a; req_be = be; req_wdata = wd;
    @(negedge clk);
    ack = rsp_ack; err = rsp_err; rd = rsp_rdata;
    req_valid = 0;
  endtask

  function automatic logic [31:0] adr(input logic [21:0] base, input int w);
    return {base, 8'(w), 2'b00};
  endfunction

  task automatic rd_chk(input string tag, input logic [31:0] a, input logic [31:0] exp);
    bit ack, err; logic [31:0] rd;
    acc(0, 1, a, 4'h0, 32'h0, ack, err, rd);
    chk(ack && !err && rd == exp, tag, rd, exp);
  endtask

  initial begin
    bit ack, err; logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp_ack && !rsp_err && rsp_rdata == 0, "R1 reset outputs", {30'b0, rsp_ack, rsp_err}, 32'h0);
    acc(0, 1, 32'h0, 4'h0, 32'h0, ack, err, rd);
    chk(!ack && !err, "R1 R10 disabled banks silent after reset", {30'b0, ack, err}, 32'h0);

    for (int b = 0; b < 4; b++) begin
      bb[b] = 22'h100 + 22'(b * 37);
      cfg(b, bb[b], 1, 0, 0);
    end
    for (int b = 0; b < 4; b++)
      for (int w = 0; w < 256; w++) begin
        logic [31:0] d;
        d = 32'hA5000000 ^ (32'(b) << 20) ^ (32'(w) * 32'h01010101) ^ (32'(w) << 13);
        acc(1, 1, adr(bb[b], w), 4'hF, d, ack, err, rd);
        chk(ack && !err, "R2 write acknowledged", {30'b0, ack, err}, 32'h2);
        model[b][w] = d;
      end
    for (int b = 0; b < 4; b++)
      for (int w = 0; w < 256; w++)
        rd_chk("R3 read back", adr(bb[b], w), model[b][w]);

    for (int be = 0; be < 16; be++) begin
      logic [31:0] d;
      d = (32'(be) * 32'h11111111) ^ 32'h5A5A5A5A;
      acc(1, 1, adr(bb[2], 5), 4'(be), d, ack, err, rd);
      chk(ack && !err, "R4 byte write ack", {30'b0, ack, err}, 32'h2);
      for (int i = 0; i < 4; i++) if (be[i]) model[2][5][8*i +: 8] = d[8*i +: 8];
      rd_chk("R4 byte lanes", adr(bb[2], 5), model[2][5]);
    end

    for (int at = 0; at < 4; at++) begin
      cfg(1, bb[1], 1, at[0], at[1]);
      for (int pv = 0; pv < 2; pv++)
        for (int wr = 0; wr < 2; wr++) begin
          bit ok;
          logic [31:0] d;
          ok = !(at[0] && pv == 0) && !(at[1] && wr == 1);
          d = 32'hC0DE0000 | 32'(at * 16 + pv * 4 + wr);
          acc(wr[0], pv[0], adr(bb[1], 7), 4'hF, d, ack, err, rd);
          chk(ack == ok && err == !ok, ok ? "R2 permitted access" : (at[0] && pv == 0 ? "R5 user refused" : "R6 write refused"),
              {30'b0, ack, err}, {30'b0, ok, !ok});
          if (wr == 0)
            chk(rd == (ok ? model[1][7] : 32'h0), ok ? "R3 permitted read data" : "R5 refused read zero", rd, ok ? model[1][7] : 32'h0);
          if (wr == 1 && ok) model[1][7] = d;
          rd_chk("R5 R6 memory after access", adr(bb[1], 7), model[1][7]);
        end
    end
    cfg(1, bb[1], 1, 0, 0);

    acc(0, 1, adr(bb[3], 9), 4'h0, 32'h0, ack, err, rd);
    cfg(3, 22'h3FFFFF, 1, 0, 0);
    acc(0, 1, adr(bb[3], 9), 4'h0, 32'h0, ack, err, rd);
    chk(!ack && !err, "R9 old range silent", {30'b0, ack, err}, 32'h0);
    bb[3] = 22'h3FFFFF;
    rd_chk("R9 contents follow bank", adr(bb[3], 9), model[3][9]);
    rd_chk("R9 top of address space", adr(bb[3], 255), model[3][255]);

    cfg(2, bb[0], 1, 0, 0);
    rd_chk("R7 lowest bank read", adr(bb[0], 3), model[0][3]);
    acc(1, 1, adr(bb[0], 3), 4'hF, 32'h600DF00D, ack, err, rd);
    chk(ack && !err, "R7 overlap write ack", {30'b0, ack, err}, 32'h2);
    model[0][3] = 32'h600DF00D;
    cfg(0, bb[0], 0, 0, 0);
    rd_chk("R10 disabled bank skipped, R7 upper bank untouched", adr(bb[0], 3), model[2][3]);
    cfg(0, bb[0], 1, 0, 1);
    acc(1, 1, adr(bb[0], 3), 4'hF, 32'hDEADBEEF, ack, err, rd);
    chk(!ack && err, "R7 lowest bank attributes decide", {30'b0, ack, err}, 32'h1);
    rd_chk("R7 lowest bank data kept", adr(bb[0], 3), model[0][3]);
    cfg(0, bb[0], 0, 0, 0);
    rd_chk("R7 upper bank data kept", adr(bb[0], 3), model[2][3]);
    cfg(0, bb[0], 1, 0, 0);
    cfg(2, bb[2], 1, 0, 0);

    acc(1, 1, 32'h0000_0000, 4'hF, 32'hFFFFFFFF, ack, err, rd);
    chk(!ack && !err, "R8 unmapped write silent", {30'b0, ack, err}, 32'h0);
    acc(0, 0, 32'h0001_2344, 4'h0, 32'h0, ack, err, rd);
    chk(!ack && !err, "R8 unmapped read silent", {30'b0, ack, err}, 32'h0);
    for (int b = 0; b < 4; b++) rd_chk("R8 banks unchanged", adr(bb[b], 0), model[b][0]);

    @(negedge clk);
    chk(!rsp_ack && !rsp_err, "R2 single-cycle response", {30'b0, rsp_ack, rsp_err}, 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule